// File: doc/BRIEF.md
# Byte-Serial 64b66b Transmit Framer

This block sits between the read side of an asynchronous FIFO and an 8:1 serializer. It takes 64-bit words from the FIFO and frames each one as a 66-bit block: a 2-bit sync header followed by a 64-bit payload. The payload is scrambled one byte per clock with a self-synchronous scrambler whose polynomial is 1 + x^39 + x^58. The block then emits a continuous stream of 8-bit words, which the serializer shifts out LSB first. The byte clock runs at one eighth of the line rate.

When the FIFO is empty at the start of a block, the framer sends a control block of idle fill in its place, so the line never stops. A 66-bit block does not fit a whole number of bytes. A small bit accumulator therefore packs headers and payload back to back, and after every four blocks one byte slot pushes nothing new while the accumulator drains. A sequencer walks through three named states: HEAD (header plus payload byte 0, where the FIFO decision is made), BODY (payload bytes 1 to 7) and SLIP (the drain slot). Its transitions are HEAD→BODY, BODY→BODY (bytes 1 to 6), BODY→HEAD (end of block), BODY→SLIP (end of every fourth block) and SLIP→HEAD. Reset leaves the sequencer in HEAD.

Top module: `tx66_framer`

## Requirements
- R1: A synchronous active-high `rst` holds `tx_data` at 0. The cycle in which `rst` is first sampled low is the header slot of a new block. The scrambler state then starts from the parameter `SEED`.
- R2: `fifo_rd` is high for exactly one cycle per block. This happens only in the header slot, and only when `fifo_empty` is low. The word on `fifo_data` is used in that same cycle, which assumes a show-ahead FIFO. During reset `fifo_rd` stays low.
- R3: If `fifo_empty` is high in the header slot, the block is an idle control block. Payload byte 0 is 0x78 and payload bytes 1 to 7 are 0x00.
- R4: The header is not scrambled. A data block sends 0 then 1 on the line, and a control block sends 1 then 0.
- R5: Payload byte k is word bits [8k+7:8k]. Byte 0 is sent first, and each byte is sent LSB first.
- R6: Each payload bit goes out as d ^ s[38] ^ s[57], where s[0] holds the most recently sent scrambled bit. Header bits do not advance the state, and the state carries over across blocks, both data and idle.
- R7: After every clock edge out of reset, `tx_data` carries the next 8 line bits, with bit 0 the earliest. The stream has no gaps or padding. The first block's bits begin on the first edge after reset is released.
- R8: After every fourth block there is one slot in which nothing new is scrambled and the FIFO is not read. Four blocks therefore take exactly 33 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock (line rate / 8) |
| rst | input | 1 | Synchronous reset, active high |
| fifo_empty | input | 1 | FIFO has no word to offer |
| fifo_data | input | 64 | Show-ahead FIFO head word |
| fifo_rd | output | 1 | Pops the FIFO head at the next edge |
| tx_data | output | 8 | Line bits for the serializer, bit 0 first |

## Verification
The hardest case to reach is a drain slot that lands next to a change between data and idle blocks. The same case must also hold across a reset that arrives in the middle of a block, with words still waiting in the FIFO. The stimulus gets there in three ways. It alternates a FIFO that never runs dry with one that is fed a word only every thirteen cycles, so empty flags fall at many phases of the 33-cycle pattern. It also applies reset while data is flowing. A bit-serial reference scrambler predicts every output byte. A bit-serial descrambler on the output recovers each block and compares its header and payload with what was sent.

// File: rtl/tx66_pkg.sv
package tx66_pkg;

    // Sequencer states of the framer
    typedef enum logic [1:0] {
        ST_HEAD = 2'd0,
        ST_BODY = 2'd1,
        ST_SLIP = 2'd2
    } slot_e;

    // Header values, bit 0 leaves first
    localparam logic [1:0] HDR_DATA = 2'b10;
    localparam logic [1:0] HDR_CTRL = 2'b01;

    // Control type of the idle block
    localparam logic [7:0] IDLE_TYPE = 8'h78;

    // Scrambler polynomial 1 + x^39 + x^58
    localparam int SCR_LEN   = 58;
    localparam int SCR_TAP_A = 38;
    localparam int SCR_TAP_B = 57;

endpackage

// File: rtl/tx66_scrambler.sv
module tx66_scrambler
    import tx66_pkg::*;
#(
    parameter int                   W    = 8,
    parameter logic [SCR_LEN-1:0]   SEED = 58'h155_5555_5555_5555
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [SCR_LEN-1:0] state_q;
    logic [SCR_LEN-1:0] state_nxt;

    always_comb begin
        logic [SCR_LEN-1:0] s;
        logic               o;
        s    = state_q;
        dout = '0;
        for (int i = 0; i < W; i++) begin
            o       = din[i] ^ s[SCR_TAP_A] ^ s[SCR_TAP_B];
            dout[i] = o;
            s       = {s[SCR_LEN-2:0], o};
        end
        state_nxt = s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEED;
        end else if (en) begin
            state_q <= state_nxt;
        end
    end

endmodule

// File: rtl/tx66_gearbox.sv
module tx66_gearbox #(
    parameter int BYTE_W = 8,
    parameter int HDR_W  = 2,
    localparam int IN_W  = BYTE_W + HDR_W,
    localparam int ACC_W = 2 * BYTE_W + HDR_W,
    localparam int LVL_W = $clog2(ACC_W + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_en,
    input  logic [HDR_W-1:0]  hdr,
    input  logic              byte_en,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] tx_data,
    output logic [LVL_W-1:0]  level
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] merged;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] n_in;
    logic [IN_W-1:0]  in_bits;

    always_comb begin
        if (hdr_en) begin
            in_bits = {byte_in, hdr};
            n_in    = LVL_W'(IN_W);
        end else if (byte_en) begin
            in_bits = {{HDR_W{1'b0}}, byte_in};
            n_in    = LVL_W'(BYTE_W);
        end else begin
            in_bits = '0;
            n_in    = '0;
        end
        merged = acc_q | (ACC_W'(in_bits) << lvl_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            lvl_q   <= '0;
            tx_data <= '0;
        end else begin
            tx_data <= merged[BYTE_W-1:0];
            acc_q   <= merged >> BYTE_W;
            lvl_q   <= lvl_q + n_in - LVL_W'(BYTE_W);
        end
    end

    assign level = lvl_q;

endmodule

// File: rtl/tx66_slot_fsm.sv
module tx66_slot_fsm
    import tx66_pkg::*;
#(
    parameter int  BYTES      = 8,
    parameter int  SLIP_EVERY = 4,
    localparam int IDX_W      = $clog2(BYTES),
    localparam int BLK_W      = (SLIP_EVERY > 1) ? $clog2(SLIP_EVERY) : 1
) (
    input  logic             clk,
    input  logic             rst,
    output slot_e            state,
    output logic [IDX_W-1:0] byte_idx,
    output logic             head_slot,
    output logic             push_byte
);

    slot_e            state_q;
    slot_e            state_nxt;
    logic [IDX_W-1:0] idx_q;
    logic [BLK_W-1:0] blk_q;
    logic             last_byte;
    logic             last_blk;

    assign last_byte = (idx_q == IDX_W'(BYTES - 1));
    assign last_blk  = (blk_q == BLK_W'(SLIP_EVERY - 1));

    // Next-state decision
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_HEAD: state_nxt = ST_BODY;
            ST_BODY: begin
                if (last_byte) begin
                    state_nxt = last_blk ? ST_SLIP : ST_HEAD;
                end
            end
            ST_SLIP: state_nxt = ST_HEAD;
            default: state_nxt = ST_HEAD;
        endcase
    end

    // State register with slot counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_HEAD;
            idx_q   <= '0;
            blk_q   <= '0;
        end else begin
            state_q <= state_nxt;
            if (state_q == ST_SLIP || last_byte) begin
                idx_q <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
            if (state_q == ST_BODY && last_byte) begin
                blk_q <= last_blk ? '0 : blk_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        state     = state_q;
        byte_idx  = idx_q;
        head_slot = !rst && (state_q == ST_HEAD);
        push_byte = !rst && (state_q != ST_SLIP);
    end

endmodule

// File: rtl/tx66_framer.sv
module tx66_framer
    import tx66_pkg::*;
#(
    parameter int                 DATA_W = 64,
    parameter int                 BYTE_W = 8,
    parameter logic [SCR_LEN-1:0] SEED   = 58'h155_5555_5555_5555
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] fifo_data,
    output logic              fifo_rd,
    output logic [BYTE_W-1:0] tx_data
);

    localparam int HDR_W      = 2;
    localparam int BYTES      = DATA_W / BYTE_W;
    localparam int IDX_W      = $clog2(BYTES);
    localparam int SLIP_EVERY = BYTE_W / HDR_W;
    localparam int LVL_W      = $clog2(2 * BYTE_W + HDR_W + 1);

    slot_e             slot_state;
    logic [IDX_W-1:0]  byte_idx;
    logic              head_slot;
    logic              push_byte;
    logic [DATA_W-1:0] sel_word;
    logic [DATA_W-1:0] blk_q;
    logic [DATA_W-1:0] blk_shift;
    logic [HDR_W-1:0]  hdr_sel;
    logic [BYTE_W-1:0] plain_byte;
    logic [BYTE_W-1:0] scr_byte;
    logic [LVL_W-1:0]  gb_level;

    tx66_slot_fsm #(
        .BYTES      (BYTES),
        .SLIP_EVERY (SLIP_EVERY)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .state     (slot_state),
        .byte_idx  (byte_idx),
        .head_slot (head_slot),
        .push_byte (push_byte)
    );

    // Block selection: live word or idle fill
    always_comb begin
        sel_word = fifo_empty ? DATA_W'(IDLE_TYPE) : fifo_data;
        hdr_sel  = fifo_empty ? HDR_CTRL : HDR_DATA;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q <= '0;
        end else if (head_slot) begin
            blk_q <= sel_word;
        end
    end

    assign blk_shift  = blk_q >> (int'(byte_idx) * BYTE_W);
    assign plain_byte = head_slot ? sel_word[BYTE_W-1:0] : blk_shift[BYTE_W-1:0];
    assign fifo_rd    = head_slot && !fifo_empty;

    tx66_scrambler #(
        .W    (BYTE_W),
        .SEED (SEED)
    ) u_scr (
        .clk  (clk),
        .rst  (rst),
        .en   (push_byte),
        .din  (plain_byte),
        .dout (scr_byte)
    );

    tx66_gearbox #(
        .BYTE_W (BYTE_W),
        .HDR_W  (HDR_W)
    ) u_gbx (
        .clk     (clk),
        .rst     (rst),
        .hdr_en  (head_slot),
        .hdr     (hdr_sel),
        .byte_en (push_byte),
        .byte_in (scr_byte),
        .tx_data (tx_data),
        .level   (gb_level)
    );

endmodule

// File: rtl/tx66_framer_chk.sv
module tx66_framer_chk
    import tx66_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LVL_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              fifo_empty,
    input logic              fifo_rd,
    input logic [BYTE_W-1:0] tx_data,
    input slot_e             slot_state,
    input logic [LVL_W-1:0]  gb_level
);

    p_reset_clear_r1: assert property (@(posedge clk)
        $fell(rst) |-> tx_data == '0);

    p_rd_needs_data_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

    p_rd_head_only_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> slot_state == ST_HEAD);

    p_rd_single_r2: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |=> !fifo_rd);

    p_head_takes_word_r3: assert property (@(posedge clk) disable iff (rst)
        (slot_state == ST_HEAD && !fifo_empty) |-> fifo_rd);

    p_level_bound_r7: assert property (@(posedge clk) disable iff (rst)
        gb_level <= LVL_W'(BYTE_W) && !gb_level[0]);

    p_slip_drains_r8: assert property (@(posedge clk) disable iff (rst)
        slot_state == ST_SLIP |-> gb_level == LVL_W'(BYTE_W));

    p_slip_single_r8: assert property (@(posedge clk) disable iff (rst)
        slot_state == ST_SLIP |=> slot_state == ST_HEAD);

endmodule

bind tx66_framer tx66_framer_chk #(
    .BYTE_W (BYTE_W),
    .LVL_W  (LVL_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .fifo_empty (fifo_empty),
    .fifo_rd    (fifo_rd),
    .tx_data    (tx_data),
    .slot_state (slot_state),
    .gb_level   (gb_level)
);

// File: tb/tx66_framer_tb.sv
module tx66_framer_tb;

    localparam int          DATA_W = 64;
    localparam int          BYTE_W = 8;
    localparam logic [57:0] SEED   = 58'h155_5555_5555_5555;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              fifo_empty = 1'b1;
    logic [DATA_W-1:0] fifo_data = '0;
    logic              fifo_rd;
    logic [BYTE_W-1:0] tx_data;

    always #4 clk = ~clk;

    tx66_framer #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .SEED(SEED)) u_dut (
        .clk        (clk),
        .rst        (rst),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_data),
        .fifo_rd    (fifo_rd),
        .tx_data    (tx_data)
    );

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    logic        exp_bits[$];
    logic [65:0] blk_q[$];
    logic [63:0] fq[$];
    logic [57:0] ref_s = SEED;
    bit          pop_pending = 0;
    int          pos = 0;
    int          mode = 0;
    int          word_no = 0;
    int          gcyc = 0;
    int          rd_count = 0;

    task automatic check(input bit ok, input string tag, input logic [65:0] act, input logic [65:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] word_gen(input int n);
        case (n)
            0:       return 64'h0;
            1:       return '1;
            2:       return 64'h78;
            3:       return 64'h0807060504030201;
            default: return (64'(n) * 64'h9E37_79B9_7F4A_7C15) ^ 64'h0123_4567_89AB_CDEF;
        endcase
    endfunction

    // Driver side: expected 66-bit block through the bit-serial reference scrambler
    task automatic push_block(input logic [65:0] b);
        logic o;
        blk_q.push_back(b);
        for (int i = 0; i < 66; i++) begin
            if (i < 2) begin
                exp_bits.push_back(b[i]);
            end else begin
                o     = b[i] ^ ref_s[38] ^ ref_s[57];
                ref_s = {ref_s[56:0], o};
                exp_bits.push_back(o);
            end
        end
    endtask

    task automatic cycle_body();
        bit start;
        if (pop_pending) void'(fq.pop_front());
        pop_pending = 0;
        gcyc++;
        if (mode == 1 && fq.size() < 2) fq.push_back(word_gen(word_no++));
        if (mode == 2 && (gcyc % 13) == 0) fq.push_back(word_gen(word_no++));
        fifo_empty = (fq.size() == 0);
        fifo_data  = fifo_empty ? '0 : fq[0];
        start = (pos < 32) && ((pos % 8) == 0);
        if (start) begin
            if (!fifo_empty) begin
                push_block({fq[0], 2'b10});
                pop_pending = 1;
            end else begin
                push_block({64'h78, 2'b01});
            end
        end
        #1;
        if (fifo_rd) rd_count++;
        if (pos == 32)
            check(fifo_rd == 1'b0, "R8 slip slot read", 66'(fifo_rd), 66'(0));
        else
            check(fifo_rd == (start && !fifo_empty), "R2 read strobe", 66'(fifo_rd), 66'(start && !fifo_empty));
        pos = (pos == 32) ? 0 : pos + 1;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cycle_body();
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        if (pop_pending) void'(fq.pop_front());
        pop_pending = 0;
        rst = 1'b1;
        exp_bits.delete();
        blk_q.delete();
        ref_s = SEED;
        pos = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            #1;
            check(fifo_rd == 1'b0, "R2 no read in reset", 66'(fifo_rd), 66'(0));
        end
        rst = 1'b0;
        cycle_body();
    endtask

    // Monitor: compares each output byte and descrambles the received blocks
    int          rcnt = 0;
    int          live = 0;
    int          rx_n = 0;
    logic [65:0] rx_blk;
    logic [57:0] ds = SEED;

    always @(negedge clk) begin
        logic [7:0]  eb;
        logic [65:0] eblk;
        logic        b;
        #2;
        if (rst) begin
            rcnt++;
            live = 0;
            rx_n = 0;
            ds   = SEED;
            if (rcnt >= 2) check(tx_data == '0, "R1 output in reset", 66'(tx_data), 66'(0));
        end else begin
            rcnt = 0;
            live++;
            if (live >= 2) begin
                if (exp_bits.size() < 8) begin
                    check(1'b0, "R7 stream ahead of prediction", 66'(exp_bits.size()), 66'(8));
                end else begin
                    for (int i = 0; i < 8; i++) eb[i] = exp_bits.pop_front();
                    if (live <= 10)
                        check(tx_data == eb, "R1 seeded first block", 66'(tx_data), 66'(eb));
                    else
                        check(tx_data == eb, "R6 R7 line byte", 66'(tx_data), 66'(eb));
                end
                for (int i = 0; i < 8; i++) begin
                    b = tx_data[i];
                    if (rx_n < 2) begin
                        rx_blk[rx_n] = b;
                    end else begin
                        rx_blk[rx_n] = b ^ ds[38] ^ ds[57];
                        ds = {ds[56:0], b};
                    end
                    rx_n++;
                    if (rx_n == 66) begin
                        rx_n = 0;
                        if (blk_q.size() > 0) begin
                            eblk = blk_q.pop_front();
                            check(rx_blk[1:0] == eblk[1:0], "R4 sync header", 66'(rx_blk[1:0]), 66'(eblk[1:0]));
                            if (eblk[1:0] == 2'b01)
                                check(rx_blk == eblk, "R3 idle block", rx_blk, eblk);
                            else
                                check(rx_blk == eblk, "R5 data payload", rx_blk, eblk);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(3);
        mode = 0;
        step(40);                  // R3 idle-only stream
        mode = 1;
        rd_count = 0;
        step(330);                 // R8: ten 33-cycle periods of back-to-back data
        check(rd_count == 40, "R8 reads per 330 cycles", 66'(rd_count), 66'(40));
        mode = 2;
        step(400);                 // sparse words: data and idle mixed at all phases
        mode = 0;
        step(30);
        mode = 1;
        step(21);
        do_reset(2);               // reset mid-block with words pending (R1)
        step(150);
        mode = 2;
        step(200);
        mode = 0;
        step(40);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule